// File: doc/BRIEF.md
# SMM Region Configuration Register File

This block holds the configuration that places the system-management code region in physical memory: a region base, a power-of-two region size, and the 32-bit physical address of the state-save header. Software reaches it through an indexed configuration port. Each access carries a register index, a write strobe with a 32-bit data word, or a read strobe. The block returns read data one clock after the read strobe. It drives the decoded base, the last byte of the region (the limit), an enable flag and the header address to the memory decoder that uses them.

A control register at index 0xC3 is always reachable. Bit 4 of that register opens the two region registers. While the bit is clear, the region registers ignore writes and read as zero.

Writing the region register has a side effect. In the same clock edge it places the header at the top of the new region, which is the base plus the size. Software therefore writes the region register first and any explicit header address afterwards. For one cycle after each accepted region write, the block raises a pulse that tells neighbouring logic the header address was recomputed.

Top module: `smm_region_cfg`

## Requirements
- R1: After reset, every output is zero, and all three registers read back as zero.
- R2: The control register at index 0xC3 accepts writes at any time. A read returns the last written byte in bits 7:0 and zeros above. Bit 4 of this register is the map enable.
- R3: While map enable is clear, writes to the region register (index 0xB0) and the header register (index 0xB4) change nothing, and reads of these indices return zero.
- R4: The region register stores the base in bits 31:12 and a size code in bits 3:0, and reads bits 11:4 as zero. The smmBase output is the stored base with 12 zero bits appended. A size code k from 1 to 15 enables the region (smmEnable=1) with a size of 4096·2^(k-1) bytes, and smmLimit is base+size-1. Size code 0 gives smmEnable=0 and smmLimit=0.
- R5: An accepted region write with a nonzero size code sets the header address to base+size, modulo 2^32, on the same clock edge that updates the region.
- R6: An accepted region write with size code 0 leaves the header address unchanged.
- R7: An accepted header write stores data bits 31:2 and forces bits 1:0 to zero. A header write that follows a region write replaces the derived address.
- R8: hdrRecalc is high for exactly the one cycle that follows each accepted region write, including writes with size code 0, and is low at all other times.
- R9: A read captures the addressed register at the clock edge where cfgRd is high. cfgRdata holds that value until the next read. Any index other than 0xC3, 0xB0 or 0xB4 reads as zero, and writes to such an index have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgIdx | input | 8 | Register index of the current access |
| cfgWr | input | 1 | Write strobe |
| cfgRd | input | 1 | Read strobe |
| cfgWdata | input | 32 | Write data |
| cfgRdata | output | 32 | Read data, valid from the cycle after the read |
| smmBase | output | 32 | Region base address |
| smmLimit | output | 32 | Last byte address of the region, zero when disabled |
| smmEnable | output | 1 | Region enabled (size code nonzero) |
| smmHdrAddr | output | 32 | Word-aligned state-save header address |
| hdrRecalc | output | 1 | One-cycle pulse after an accepted region write |

## Verification
Each register feeds an exported port directly, so a corrupted base, size code or header register shows up at smmBase, smmLimit, smmEnable or smmHdrAddr in the cycle after the faulty edge. A wrong map-enable state shows up at the same point. The region ports move when they should have held, or they fail to move, and readback of index 0xB0 or 0xB4 returns zero or non-zero when it should not. A mistake in the size decode or in the header derivation shows as a broken relation between smmLimit and smmHdrAddr (the header must equal the limit plus one). The sweep over every size code at several bases, including one that wraps at 2^32, exposes that relation within one cycle of the faulty write.

// File: rtl/smm_cfg_pkg.sv
package smm_cfg_pkg;

  // which register the read mux returns
  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_CTRL   = 2'd1,
    RD_REGION = 2'd2,
    RD_HDR    = 2'd3
  } rdSel_e;

  // strobes from the access control to the datapath
  typedef struct packed {
    logic   wrRegion;
    logic   wrHdr;
    logic   rdEn;
    rdSel_e rdSel;
  } cfgStrobe_t;

endpackage

// File: rtl/smm_cfg_ctrl.sv
module smm_cfg_ctrl
  import smm_cfg_pkg::*;
#(
  parameter int          IDX_W      = 8,
  parameter int          CTRL_W     = 8,
  parameter int          MAP_BIT    = 4,
  parameter logic [7:0]  CTRL_IDX   = 8'hC3,
  parameter logic [7:0]  REGION_IDX = 8'hB0,
  parameter logic [7:0]  HDR_IDX    = 8'hB4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic              cfgWr,
  input  logic              cfgRd,
  input  logic [CTRL_W-1:0] ctrlWdata,
  output logic [CTRL_W-1:0] ctrlVal,
  output logic              mapEn,
  output cfgStrobe_t        strb
);

  localparam logic [IDX_W-1:0] CTRL_HIT   = IDX_W'(CTRL_IDX);
  localparam logic [IDX_W-1:0] REGION_HIT = IDX_W'(REGION_IDX);
  localparam logic [IDX_W-1:0] HDR_HIT    = IDX_W'(HDR_IDX);

  logic [CTRL_W-1:0] ctrlReg;
  logic hitCtrl, hitRegion, hitHdr;

  assign hitCtrl   = (cfgIdx == CTRL_HIT);
  assign hitRegion = (cfgIdx == REGION_HIT);
  assign hitHdr    = (cfgIdx == HDR_HIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (cfgWr && hitCtrl) begin
      ctrlReg <= ctrlWdata;
    end
  end

  assign ctrlVal = ctrlReg;
  assign mapEn   = ctrlReg[MAP_BIT];

  always_comb begin
    strb          = '0;
    strb.wrRegion = cfgWr && hitRegion && mapEn;
    strb.wrHdr    = cfgWr && hitHdr && mapEn;
    strb.rdEn     = cfgRd;
    if (hitCtrl)                strb.rdSel = RD_CTRL;
    else if (hitRegion && mapEn) strb.rdSel = RD_REGION;
    else if (hitHdr && mapEn)    strb.rdSel = RD_HDR;
    else                         strb.rdSel = RD_NONE;
  end

  // R2
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && cfgIdx == CTRL_HIT) |=> (ctrlVal == $past(ctrlWdata)));

  // R2
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgWr && cfgIdx == CTRL_HIT) |=> $stable(ctrlVal));

endmodule

// File: rtl/smm_cfg_dp.sv
module smm_cfg_dp
  import smm_cfg_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BASE_LSB  = 12,
  parameter int CODE_W    = 4,
  parameter int HDR_ALIGN = 2,
  parameter int CTRL_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strb,
  input  logic [ADDR_W-1:0] wdata,
  input  logic [CTRL_W-1:0] ctrlVal,
  output logic [ADDR_W-1:0] rdata,
  output logic [ADDR_W-1:0] smmBase,
  output logic [ADDR_W-1:0] smmLimit,
  output logic              smmEnable,
  output logic [ADDR_W-1:0] smmHdrAddr,
  output logic              hdrRecalc
);

  localparam int BASE_W  = ADDR_W - BASE_LSB;
  localparam int GAP_W   = BASE_LSB - CODE_W;
  localparam int LUT_N   = 1 << CODE_W;
  localparam int HDR_W   = ADDR_W - HDR_ALIGN;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'((1 << HDR_ALIGN) - 1);

  logic [BASE_W-1:0] baseReg;
  logic [CODE_W-1:0] codeReg;
  logic [HDR_W-1:0]  hdrReg;
  logic              recalcQ;
  logic [ADDR_W-1:0] rdataQ;

  // region size in bytes per size code, code 0 means disabled
  logic [ADDR_W-1:0] sizeLut [LUT_N];
  for (genvar k = 0; k < LUT_N; k++) begin : gSize
    if (k == 0) begin : gOff
      assign sizeLut[k] = '0;
    end else begin : gOn
      assign sizeLut[k] = ADDR_W'(1) << (BASE_LSB + k - 1);
    end
  end

  // values carried by the incoming region write
  logic [BASE_W-1:0] newBase;
  logic [CODE_W-1:0] newCode;
  logic [ADDR_W-1:0] newTop;
  assign newBase = wdata[ADDR_W-1:BASE_LSB];
  assign newCode = wdata[CODE_W-1:0];
  assign newTop  = {newBase, {BASE_LSB{1'b0}}} + sizeLut[newCode];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg <= '0;
      codeReg <= '0;
      hdrReg  <= '0;
      recalcQ <= 1'b0;
    end else begin
      recalcQ <= strb.wrRegion;
      if (strb.wrRegion) begin
        baseReg <= newBase;
        codeReg <= newCode;
        if (newCode != '0) hdrReg <= newTop[ADDR_W-1:HDR_ALIGN];
      end else if (strb.wrHdr) begin
        hdrReg <= wdata[ADDR_W-1:HDR_ALIGN];
      end
    end
  end

  // exported view
  logic [ADDR_W-1:0] baseFull;
  assign baseFull   = {baseReg, {BASE_LSB{1'b0}}};
  assign smmBase    = baseFull;
  assign smmEnable  = (codeReg != '0);
  assign smmLimit   = smmEnable ? (baseFull + sizeLut[codeReg] - ADDR_W'(1)) : '0;
  assign smmHdrAddr = {hdrReg, {HDR_ALIGN{1'b0}}};
  assign hdrRecalc  = recalcQ;

  // read mux, captured on the read strobe
  logic [ADDR_W-1:0] rdMux;
  always_comb begin
    case (strb.rdSel)
      RD_CTRL:   rdMux = ADDR_W'(ctrlVal);
      RD_REGION: rdMux = {baseReg, {GAP_W{1'b0}}, codeReg};
      RD_HDR:    rdMux = smmHdrAddr;
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdataQ <= '0;
    else if (strb.rdEn) rdataQ <= rdMux;
  end
  assign rdata = rdataQ;

  // R5
  hdr_derive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrRegion && wdata[CODE_W-1:0] != '0) |=> (smmHdrAddr == smmLimit + ADDR_W'(1)));

  // R6
  hdr_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrRegion && wdata[CODE_W-1:0] == '0) |=> $stable(smmHdrAddr));

  // R7
  hdr_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrHdr |=> (smmHdrAddr == ($past(wdata) & ~ALIGN_MASK)));

  // R8
  recalc_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrRegion |=> hdrRecalc);

  // R8
  recalc_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrRegion |=> !hdrRecalc);

  // R4
  limit_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !smmEnable |-> (smmLimit == '0));

endmodule

// File: rtl/smm_region_cfg.sv
module smm_region_cfg
  import smm_cfg_pkg::*;
#(
  parameter int         ADDR_W     = 32,
  parameter int         IDX_W      = 8,
  parameter int         BASE_LSB   = 12,
  parameter int         CODE_W     = 4,
  parameter int         HDR_ALIGN  = 2,
  parameter int         CTRL_W     = 8,
  parameter int         MAP_BIT    = 4,
  parameter logic [7:0] CTRL_IDX   = 8'hC3,
  parameter logic [7:0] REGION_IDX = 8'hB0,
  parameter logic [7:0] HDR_IDX    = 8'hB4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic              cfgWr,
  input  logic              cfgRd,
  input  logic [ADDR_W-1:0] cfgWdata,
  output logic [ADDR_W-1:0] cfgRdata,
  output logic [ADDR_W-1:0] smmBase,
  output logic [ADDR_W-1:0] smmLimit,
  output logic              smmEnable,
  output logic [ADDR_W-1:0] smmHdrAddr,
  output logic              hdrRecalc
);

  cfgStrobe_t        strb;
  logic [CTRL_W-1:0] ctrlVal;
  logic              mapEn;

  smm_cfg_ctrl #(
    .IDX_W(IDX_W), .CTRL_W(CTRL_W), .MAP_BIT(MAP_BIT),
    .CTRL_IDX(CTRL_IDX), .REGION_IDX(REGION_IDX), .HDR_IDX(HDR_IDX)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .cfgIdx(cfgIdx), .cfgWr(cfgWr), .cfgRd(cfgRd),
    .ctrlWdata(cfgWdata[CTRL_W-1:0]), .ctrlVal(ctrlVal), .mapEn(mapEn), .strb(strb)
  );

  smm_cfg_dp #(
    .ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB), .CODE_W(CODE_W),
    .HDR_ALIGN(HDR_ALIGN), .CTRL_W(CTRL_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(cfgWdata), .ctrlVal(ctrlVal),
    .rdata(cfgRdata), .smmBase(smmBase), .smmLimit(smmLimit),
    .smmEnable(smmEnable), .smmHdrAddr(smmHdrAddr), .hdrRecalc(hdrRecalc)
  );

  // R3
  map_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && !mapEn && (cfgIdx == IDX_W'(REGION_IDX) || cfgIdx == IDX_W'(HDR_IDX)))
      |=> ($stable(smmBase) && $stable(smmHdrAddr) && $stable(smmEnable) && !hdrRecalc));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRd |=> $stable(cfgRdata));

endmodule

// File: tb/tb_smm_region_cfg.sv
module tb_smm_region_cfg;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  cfgIdx;
  logic        cfgWr, cfgRd;
  logic [31:0] cfgWdata;
  logic [31:0] cfgRdata, smmBase, smmLimit, smmHdrAddr;
  logic        smmEnable, hdrRecalc;

  int vecCnt = 0;
  int missCnt = 0;
  logic [31:0] modelHdr;

  localparam logic [7:0] IX_CTRL = 8'hC3;
  localparam logic [7:0] IX_REG  = 8'hB0;
  localparam logic [7:0] IX_HDR  = 8'hB4;

  always #4 clk = ~clk;

  smm_region_cfg dut (
    .clk(clk), .rstN(rstN), .cfgIdx(cfgIdx), .cfgWr(cfgWr), .cfgRd(cfgRd),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .smmBase(smmBase), .smmLimit(smmLimit),
    .smmEnable(smmEnable), .smmHdrAddr(smmHdrAddr), .hdrRecalc(hdrRecalc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCnt++;
    if (act !== exp) begin
      missCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one write; returns at the falling edge after the capturing edge
  task automatic doWrite(input logic [7:0] idx, input logic [31:0] data);
    @(negedge clk);
    cfgIdx = idx; cfgWdata = data; cfgWr = 1'b1;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic doRead(input logic [7:0] idx, output logic [31:0] data);
    @(negedge clk);
    cfgIdx = idx; cfgRd = 1'b1;
    @(negedge clk);
    cfgRd = 1'b0;
    data = cfgRdata;
  endtask

  function automatic logic [31:0] sizeOf(input int code);
    return (code == 0) ? 32'd0 : (32'd4096 << (code - 1));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    missCnt++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] bases [4];
    bases[0] = 32'h0000_0000; bases[1] = 32'h1234_5000;
    bases[2] = 32'hFFFF_F000; bases[3] = 32'h8000_0000;
    rstN = 1'b0; cfgIdx = '0; cfgWr = 1'b0; cfgRd = 1'b0; cfgWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1 base", smmBase, 32'd0);
    check("R1 limit", smmLimit, 32'd0);
    check("R1 enable", {31'd0, smmEnable}, 32'd0);
    check("R1 hdr", smmHdrAddr, 32'd0);
    check("R1 recalc", {31'd0, hdrRecalc}, 32'd0);
    check("R1 rdata", cfgRdata, 32'd0);
    doRead(IX_CTRL, rd); check("R1 ctrl read", rd, 32'd0);

    // R3 gated while map enable clear
    doWrite(IX_REG, 32'hABCD_E003);
    check("R3 recalc gated", {31'd0, hdrRecalc}, 32'd0);
    check("R3 base gated", smmBase, 32'd0);
    doWrite(IX_HDR, 32'h5555_5554);
    check("R3 hdr gated", smmHdrAddr, 32'd0);

    // R2 control register sweep of bit patterns
    for (int v = 0; v < 256; v += 17) begin
      doWrite(IX_CTRL, 32'hFFFF_FF00 | v);
      doRead(IX_CTRL, rd); check("R2 ctrl readback", rd, v);
    end
    doWrite(IX_CTRL, 32'h0000_00EF);
    doRead(IX_REG, rd); check("R3 region read zero", rd, 32'd0);
    doWrite(IX_CTRL, 32'h0000_0010);

    // R4 R5 R6 R8 sweep all codes over several bases
    modelHdr = 32'd0;
    for (int b = 0; b < 4; b++) begin
      for (int c = 0; c < 16; c++) begin
        logic [31:0] w;
        w = bases[b] | 32'h0000_0FF0 | c;
        doWrite(IX_REG, w);
        check("R8 pulse", {31'd0, hdrRecalc}, 32'd1);
        check("R4 base", smmBase, bases[b]);
        check("R4 enable", {31'd0, smmEnable}, (c != 0) ? 32'd1 : 32'd0);
        check("R4 limit", smmLimit, (c != 0) ? bases[b] + sizeOf(c) - 32'd1 : 32'd0);
        if (c != 0) modelHdr = bases[b] + sizeOf(c);
        check((c != 0) ? "R5 derived hdr" : "R6 hdr kept", smmHdrAddr, modelHdr);
        doRead(IX_REG, rd);
        check("R8 pulse ends", {31'd0, hdrRecalc}, 32'd0);
        check("R4 region readback", rd, bases[b] | c);
      end
    end

    // R7 explicit header writes, alignment and override
    doWrite(IX_REG, 32'h0004_0002);
    check("R5 hdr before override", smmHdrAddr, 32'h0004_2000);
    for (int k = 0; k < 4; k++) begin
      doWrite(IX_HDR, 32'h0003_FF00 | k);
      check("R7 hdr override", smmHdrAddr, 32'h0003_FF00);
      check("R8 no pulse on hdr write", {31'd0, hdrRecalc}, 32'd0);
      doRead(IX_HDR, rd); check("R7 hdr readback", rd, 32'h0003_FF00);
    end
    check("R7 region unaffected", smmBase, 32'h0004_0000);

    // R9 unmapped index and read hold
    doWrite(8'h42, 32'hFFFF_FFFF);
    check("R9 unmapped write", smmHdrAddr, 32'h0003_FF00);
    check("R9 unmapped no pulse", {31'd0, hdrRecalc}, 32'd0);
    doRead(8'h42, rd); check("R9 unmapped read", rd, 32'd0);
    doRead(IX_CTRL, rd);
    repeat (3) @(negedge clk);
    check("R9 rdata holds", cfgRdata, 32'h0000_0010);

    // R3 clear map enable: values frozen and hidden
    doWrite(IX_CTRL, 32'h0000_0000);
    doWrite(IX_REG, 32'h7770_0005);
    doWrite(IX_HDR, 32'h1111_1110);
    check("R3 base frozen", smmBase, 32'h0004_0000);
    check("R3 hdr frozen", smmHdrAddr, 32'h0003_FF00);
    doRead(IX_HDR, rd); check("R3 hdr read zero", rd, 32'd0);
    doWrite(IX_CTRL, 32'h0000_0010);
    doRead(IX_REG, rd); check("R3 region kept", rd, 32'h0004_0002);

    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  end

endmodule